// File: doc/BRIEF.md
# Late-Arrival Checked Register and Memory Write Guard

This block holds one pipeline stage of data and the write port of a small local memory, and checks both against a second, later sample of the same value. The main register takes its data on the ordinary clock edge. A later sample of the same data arrives on its own input, qualified by a strobe, during the cycle after the capture. When that later sample differs from the value already taken, the captured value is judged to have been too early. The stage then marks its output invalid for that cycle and asks the upstream logic to hold. On the next edge it loads the later sample in place of the captured value, so one stall cycle absorbs the correction.

The memory write port is guarded in the same way. A write is compared against a later sample of its data in the following cycle. On a mismatch the word just written is rewritten with the later sample, and any new write offered in that cycle is dropped. A saturating counter totals every error detected by either guard. The later sample is an ordinary input, so a test can force a mismatch in any chosen cycle.

Top module: `shadow_check_reg`

## Requirements
- R1: While rst_n is low and after it is released, q_out is 0, q_vld is 0, err_o and wr_err_o are 0, err_cnt is 0, and every memory word reads as 0.
- R2: When d_vld is high at a clock edge and no mismatch is flagged (hold_o low), q_out equals that d_in after the edge. When d_vld is low at an edge, q_vld is 0 after it and q_out keeps its value.
- R3: A strobed late sample equal to q_out, in the cycle after a capture, raises no error: hold_o stays 0, q_vld stays 1, and the counter does not change.
- R4: A mismatch is a strobed late sample that differs from q_out in the cycle after a capture. During that cycle hold_o is 1 and q_vld is 0. After the next edge q_out equals the late sample, q_vld is 1, and err_o is 1.
- R5: At the edge that restores a register value, d_in and d_vld are ignored. The offered data never reaches q_out, and q_vld is 0 one cycle later unless new data is offered.
- R6: A late-sample strobe has no effect when the previous edge captured nothing or performed a restore. No error is raised and q_out is unchanged.
- R7: A write with wr_en high stores wr_data at wr_addr. rd_data shows the word at rd_addr one clock after the address is presented.
- R8: A strobed memory late sample that differs from the word written at the previous edge sets wr_hold_o to 1 during that cycle. At the next edge that word is rewritten with the late sample, wr_err_o becomes 1, and a write offered at that edge is dropped.
- R9: err_cnt rises at each edge by the number of mismatches flagged, which is 0, 1 or 2 when register and memory fail together. It stops at its all-ones value.
- R10: err_o and wr_err_o are single-cycle pulses. A restored value is never checked again, so a strobe in the following cycle cannot raise a second error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | W | Data offered to the register stage |
| d_vld | input | 1 | d_in is to be captured at this edge |
| shd_in | input | W | Late sample of the last captured data |
| shd_stb | input | 1 | shd_in is valid this cycle |
| q_out | output | W | Register stage output |
| q_vld | output | 1 | q_out is usable this cycle |
| hold_o | output | 1 | Register mismatch seen; upstream must hold |
| err_o | output | 1 | Register restore happened at the last edge |
| wr_en | input | 1 | Memory write enable |
| wr_addr | input | AW | Memory write address |
| wr_data | input | W | Memory write data |
| wr_shd_data | input | W | Late sample of the last written data |
| wr_shd_stb | input | 1 | wr_shd_data is valid this cycle |
| wr_hold_o | output | 1 | Memory write mismatch seen; writer must hold |
| wr_err_o | output | 1 | Memory word restore happened at the last edge |
| rd_addr | input | AW | Memory read address |
| rd_data | output | W | Registered memory read data |
| err_cnt | output | CNT_W | Saturating count of detected errors |

## Verification
The register stage is driven with four patterns. A capture with no strobe shows the plain pipeline behaviour. A strobe whose sample matches separates a genuine check from a false alarm. A strobe whose sample differs exercises the invalid cycle, the restore and the dropped input together. A strobe with nothing pending shows that stale strobes are ignored. The memory is tried with a clean write and with a corrupted write that is followed by a competing write. Reading back both addresses tells the rewritten word apart from the dropped one. Failing both guards at the same edge separates an increment of two from an increment of one. A long run of errors then drives the counter into saturation.

// File: rtl/shc_pkg.sv
package shc_pkg;
  localparam int unsigned DEF_W     = 8;
  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_CNT_W = 16;

  // number of guards flagging a mismatch at one edge
  function automatic logic [1:0] err_events(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/shc_reg_stage.sv
module shc_reg_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  input  logic         d_vld,
  input  logic [W-1:0] shd_in,
  input  logic         shd_stb,
  output logic [W-1:0] q_out,
  output logic         q_vld,
  output logic         hold_o,
  output logic         err_o
);
  logic [W-1:0] main_q, main_n;
  logic         vld_q, vld_n;
  logic         pend_q, pend_n;
  logic         err_q, err_n;
  logic [W-1:0] diff;
  logic         mism;

  // per-bit disagreement between captured and late sample
  for (genvar b = 0; b < W; b++) begin : g_cmp
    assign diff[b] = main_q[b] ^ shd_in[b];
  end

  assign mism = pend_q & shd_stb & (|diff);

  always_comb begin
    main_n = main_q;
    vld_n  = 1'b0;
    pend_n = 1'b0;
    err_n  = 1'b0;
    if (mism) begin
      main_n = shd_in;
      vld_n  = 1'b1;
      err_n  = 1'b1;
    end else if (d_vld) begin
      main_n = d_in;
      vld_n  = 1'b1;
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      main_q <= main_n;
      vld_q  <= vld_n;
      pend_q <= pend_n;
      err_q  <= err_n;
    end
  end

  assign q_out  = main_q;
  assign q_vld  = vld_q & ~mism;
  assign hold_o = mism;
  assign err_o  = err_q;
endmodule

// File: rtl/shc_mem_stage.sv
module shc_mem_stage #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  wr_shd_data,
  input  logic          wr_shd_stb,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          wr_hold_o,
  output logic          wr_err_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] last_q, last_n;
  logic          pend_q, pend_n;
  logic          err_q;
  logic [W-1:0]  rd_q;
  logic [W-1:0]  stored;
  logic          mism;
  logic          take_wr;
  logic [W-1:0]  row_d;

  assign stored  = mem_q[last_q];
  assign mism    = pend_q & wr_shd_stb & (wr_shd_data != stored);
  assign take_wr = wr_en & ~mism;
  assign row_d   = mism ? wr_shd_data : wr_data;

  always_comb begin
    last_n = last_q;
    pend_n = take_wr;
    if (take_wr) last_n = wr_addr;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic row_we;
    assign row_we = mism ? (last_q == AW'(i)) : (take_wr && (wr_addr == AW'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[i] <= '0;
      else if (row_we) mem_q[i] <= row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      last_q <= last_n;
      pend_q <= pend_n;
      err_q  <= mism;
      rd_q   <= mem_q[rd_addr];
    end
  end

  assign rd_data   = rd_q;
  assign wr_hold_o = mism;
  assign wr_err_o  = err_q;
endmodule

// File: rtl/shc_err_cnt.sv
module shc_err_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W:0]   sum;
  logic             cnt_en;

  assign cnt_en = |inc;
  assign sum    = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc};

  always_comb begin
    cnt_n = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/shadow_check_reg.sv
module shadow_check_reg #(
  parameter int unsigned W     = shc_pkg::DEF_W,
  parameter int unsigned DEPTH = shc_pkg::DEF_DEPTH,
  parameter int unsigned CNT_W = shc_pkg::DEF_CNT_W,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     d_in,
  input  logic             d_vld,
  input  logic [W-1:0]     shd_in,
  input  logic             shd_stb,
  output logic [W-1:0]     q_out,
  output logic             q_vld,
  output logic             hold_o,
  output logic             err_o,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [W-1:0]     wr_shd_data,
  input  logic             wr_shd_stb,
  output logic             wr_hold_o,
  output logic             wr_err_o,
  input  logic [AW-1:0]    rd_addr,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] err_cnt
);
  logic [1:0] ev;

  shc_reg_stage #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n), .d_in(d_in), .d_vld(d_vld),
    .shd_in(shd_in), .shd_stb(shd_stb), .q_out(q_out), .q_vld(q_vld),
    .hold_o(hold_o), .err_o(err_o)
  );

  shc_mem_stage #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_shd_data(wr_shd_data), .wr_shd_stb(wr_shd_stb),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_hold_o(wr_hold_o),
    .wr_err_o(wr_err_o)
  );

  assign ev = shc_pkg::err_events(hold_o, wr_hold_o);

  shc_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev), .cnt(err_cnt)
  );
endmodule

// File: rtl/shc_guard_chk.sv
module shc_guard_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     d_in,
  input logic             d_vld,
  input logic [W-1:0]     shd_in,
  input logic             hold_o,
  input logic [W-1:0]     q_out,
  input logic             err_o,
  input logic             wr_hold_o,
  input logic             wr_err_o,
  input logic [CNT_W-1:0] err_cnt
);
  AST_CAPTURE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (d_vld && !hold_o) |=> (q_out == $past(d_in))); // R2
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) hold_o |=> (err_o && q_out == $past(shd_in))); // R4
  AST_WR_RESTORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) wr_hold_o |=> wr_err_o); // R8
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> !err_o); // R10
  AST_WR_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_err_o |=> !wr_err_o); // R10
  AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n) (&err_cnt) |=> (&err_cnt)); // R9
  AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (err_cnt >= $past(err_cnt))); // R9
endmodule

bind shadow_check_reg shc_guard_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .d_in(d_in), .d_vld(d_vld), .shd_in(shd_in),
  .hold_o(hold_o), .q_out(q_out), .err_o(err_o), .wr_hold_o(wr_hold_o),
  .wr_err_o(wr_err_o), .err_cnt(err_cnt)
);

// File: tb/sim_shadow_check_reg.sv
module sim_shadow_check_reg;
  localparam int W = 8, DEPTH = 8, CNT_W = 4, AW = 3;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk, rst_n;
  logic [W-1:0] d_in, shd_in, wr_data, wr_shd_data, q_out, rd_data;
  logic d_vld, shd_stb, q_vld, hold_o, err_o, wr_en, wr_shd_stb, wr_hold_o, wr_err_o;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0] err_cnt;

  int n_chk = 0, n_err = 0, exp_cnt = 0;
  bit done = 0;

  shadow_check_reg #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .d_in(d_in), .d_vld(d_vld), .shd_in(shd_in),
    .shd_stb(shd_stb), .q_out(q_out), .q_vld(q_vld), .hold_o(hold_o), .err_o(err_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_shd_data(wr_shd_data),
    .wr_shd_stb(wr_shd_stb), .wr_hold_o(wr_hold_o), .wr_err_o(wr_err_o),
    .rd_addr(rd_addr), .rd_data(rd_data), .err_cnt(err_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    d_vld = 0; shd_stb = 0; wr_en = 0; wr_shd_stb = 0;
  endtask

  task automatic t_reset();
    rd_addr = 3;
    step();
    chk(q_out == 0, "R1 q_out", q_out, 0);
    chk(q_vld == 0, "R1 q_vld", q_vld, 0);
    chk(err_o == 0 && wr_err_o == 0, "R1 err", {err_o, wr_err_o}, 0);
    chk(err_cnt == 0, "R1 err_cnt", err_cnt, 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
  endtask

  task automatic t_capture();
    d_vld = 1; d_in = 8'hA5;
    step();
    d_vld = 0; #1;
    chk(q_out == 8'hA5, "R2 q_out", q_out, 8'hA5);
    chk(q_vld == 1, "R2 q_vld", q_vld, 1);
    step();
    chk(q_vld == 0, "R2 idle q_vld", q_vld, 0);
    chk(q_out == 8'hA5, "R2 idle q_out", q_out, 8'hA5);
  endtask

  task automatic t_match();
    d_vld = 1; d_in = 8'h3C;
    step();
    shd_stb = 1; shd_in = 8'h3C; d_vld = 1; d_in = 8'h44; #1;
    chk(hold_o == 0, "R3 hold_o", hold_o, 0);
    chk(q_vld == 1, "R3 q_vld", q_vld, 1);
    step();
    idle(); #1;
    chk(err_o == 0, "R3 err_o", err_o, 0);
    chk(q_out == 8'h44, "R3 next q_out", q_out, 8'h44);
    chk(err_cnt == exp_cnt, "R3 err_cnt", err_cnt, exp_cnt);
    step();
  endtask

  task automatic t_mismatch();
    d_vld = 1; d_in = 8'h11;
    step();
    shd_stb = 1; shd_in = 8'h19; d_vld = 1; d_in = 8'h77; #1;
    chk(hold_o == 1, "R4 hold_o", hold_o, 1);
    chk(q_vld == 0, "R4 q_vld invalid", q_vld, 0);
    step();
    shd_stb = 1; shd_in = 8'h00; d_vld = 0; #1;
    exp_cnt++;
    chk(q_out == 8'h19, "R4 restored q_out", q_out, 8'h19);
    chk(q_vld == 1, "R4 restored q_vld", q_vld, 1);
    chk(err_o == 1, "R4 err_o", err_o, 1);
    chk(err_cnt == exp_cnt, "R9 single inc", err_cnt, exp_cnt);
    chk(hold_o == 0, "R6 strobe after restore", hold_o, 0);
    step();
    idle(); #1;
    chk(err_o == 0, "R10 err pulse", err_o, 0);
    chk(q_out == 8'h19, "R5 d_in dropped", q_out, 8'h19);
    chk(q_vld == 0, "R5 q_vld", q_vld, 0);
    chk(err_cnt == exp_cnt, "R10 no second error", err_cnt, exp_cnt);
  endtask

  task automatic t_stb_idle();
    step();
    shd_stb = 1; shd_in = 8'hFF; #1;
    chk(hold_o == 0, "R6 hold_o", hold_o, 0);
    step();
    idle(); #1;
    chk(err_o == 0, "R6 err_o", err_o, 0);
    chk(q_out == 8'h19, "R6 q_out", q_out, 8'h19);
    chk(err_cnt == exp_cnt, "R6 err_cnt", err_cnt, exp_cnt);
  endtask

  task automatic t_mem_write();
    wr_en = 1; wr_addr = 2; wr_data = 8'h5A;
    step();
    wr_en = 0; rd_addr = 2;
    step();
    chk(rd_data == 8'h5A, "R7 rd_data", rd_data, 8'h5A);
  endtask

  task automatic t_mem_mismatch();
    wr_en = 1; wr_addr = 5; wr_data = 8'h0F;
    step();
    wr_shd_stb = 1; wr_shd_data = 8'hF0; wr_en = 1; wr_addr = 6; wr_data = 8'h99; #1;
    chk(wr_hold_o == 1, "R8 wr_hold_o", wr_hold_o, 1);
    step();
    idle(); rd_addr = 5; #1;
    exp_cnt++;
    chk(wr_err_o == 1, "R8 wr_err_o", wr_err_o, 1);
    chk(err_cnt == exp_cnt, "R9 mem inc", err_cnt, exp_cnt);
    step();
    rd_addr = 6;
    chk(rd_data == 8'hF0, "R8 word rewritten", rd_data, 8'hF0);
    chk(wr_err_o == 0, "R10 wr pulse", wr_err_o, 0);
    step();
    chk(rd_data == 8'h00, "R8 write dropped", rd_data, 0);
  endtask

  task automatic t_both();
    d_vld = 1; d_in = 8'h21; wr_en = 1; wr_addr = 1; wr_data = 8'h21;
    step();
    idle(); shd_stb = 1; shd_in = 8'h22; wr_shd_stb = 1; wr_shd_data = 8'h23; #1;
    chk(hold_o && wr_hold_o, "R9 both hold", {hold_o, wr_hold_o}, 3);
    step();
    idle(); #1;
    exp_cnt += 2;
    chk(err_cnt == exp_cnt, "R9 double inc", err_cnt, exp_cnt);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 14; i++) begin
      d_vld = 1; d_in = W'(i);
      step();
      idle(); shd_stb = 1; shd_in = ~W'(i);
      step();
      idle(); #1;
      exp_cnt = (exp_cnt + 1 > CMAX) ? CMAX : exp_cnt + 1;
      chk(err_cnt == exp_cnt, "R9 count run", err_cnt, exp_cnt);
    end
    chk(err_cnt == CMAX, "R9 saturated", err_cnt, CMAX);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); d_in = 0; shd_in = 0; wr_addr = 0; wr_data = 0;
    wr_shd_data = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    t_reset();
    t_capture();
    t_match();
    t_mismatch();
    t_stb_idle();
    t_mem_write();
    t_mem_mismatch();
    t_both();
    t_saturate();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule